// File: doc/BRIEF.md
# Register Transfer/Exchange Unit

This block holds a small processor register file and moves values between its registers. The file has two 8-bit accumulators (A and B, which together also form the 16-bit D register), four 16-bit pointer registers (X, Y, U, S), a 16-bit program counter, an 8-bit condition-code register and an 8-bit direct-page register. An operation is started by a valid strobe together with a selector byte. The upper four bits of that byte name the source register and the lower four bits name the destination register. A mode input chooses between a copy (transfer) and a swap (exchange).

The operation completes at the clock edge where it is accepted. A done pulse follows one cycle later. When the program counter is written by the operation, a flow-change strobe fires in the same cycle as done, so that fetch logic can redirect. A separate load port lets the surrounding datapath write any register with the same register codes. The current contents of every register are driven out on dedicated outputs.

Top module: `regxfer_unit`

## Requirements
- R1: Synchronous active-high reset clears A, B, X, Y, U, S, CC and DP to zero and sets PC to the `RESET_PC` parameter. The `done` and `pc_changed` outputs are low after reset.
- R2: The register codes are 0=D, 1=X, 2=Y, 3=U, 4=S, 5=PC, 8=A, 9=B, 10=CC and 11=DP. The source code is `op_sel[7:4]` and the destination code is `op_sel[3:0]`. With `op_valid` high and `op_swap` low, the source value is copied into the destination and is visible on the outputs in the cycle after the accepting edge. The source is left unchanged.
- R3: D reads as {A, B}, with A as the high byte. Writing D writes its high byte into A and its low byte into B.
- R4: When a 16-bit value goes into an 8-bit register, only its low byte is kept. When an 8-bit value goes into a 16-bit register, it is zero-extended.
- R5: With `op_swap` high, both registers are read before either is written. Each register then receives the other's old value, with the sizing of R4.
- R6: A source or destination code outside the R2 list reads as all ones (16'hFFFF before sizing).
- R7: A write to a code outside the R2 list changes no register.
- R8: `pc_changed` is a one-cycle pulse in the cycle after an accepted operation that writes PC: a transfer with destination 5, or an exchange with either code equal to 5. It stays low otherwise, including for load-port writes to PC.
- R9: `done` is high for exactly the one cycle after each cycle in which `op_valid` is high.
- R10: With `ld_en` high, `ld_data` is written to the register named by `ld_code`, using the R2 codes and the R3/R4 sizing. The write is visible the next cycle. It does not raise `done` or `pc_changed`.
- R11: When writes collide on one register in the same cycle, the priority is: destination write first, then the exchange write-back to the source, then the load port. Writes to different registers in the same cycle all take effect.
- R12: In a cycle with neither `op_valid` nor `ld_en` high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Start a transfer or exchange this cycle |
| op_swap | input | 1 | 1 = exchange, 0 = transfer |
| op_sel | input | 8 | Source code [7:4], destination code [3:0] |
| ld_en | input | 1 | Load-port write enable |
| ld_code | input | 4 | Register code for the load port |
| ld_data | input | 16 | Load-port write data |
| done | output | 1 | Pulse one cycle after an accepted operation |
| pc_changed | output | 1 | Pulse when the operation wrote PC |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Pointer X |
| reg_y | output | 16 | Pointer Y |
| reg_u | output | 16 | Stack pointer U |
| reg_s | output | 16 | Stack pointer S |
| reg_pc | output | 16 | Program counter |
| reg_cc | output | 8 | Condition-code register |
| reg_dp | output | 8 | Direct-page register |

## Verification
Two functions can land in the same cycle: a load-port write and a transfer or exchange. These collisions are the main focus. The bench drives `ld_en` in the very cycle of `op_valid`, once aimed at the operation's destination and once at an unrelated register. It then reads the outputs one cycle later to confirm that the operation wins the shared register and that the unrelated load still lands. A second overlap lives inside a single exchange: swapping D with A makes both write paths hit A. That case is judged by checking that A ends with the destination-side byte while B takes the old A.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  localparam int CODE_W = 4;
  localparam int NBYTE  = 4;   // A, B, CC, DP
  localparam int NWORD  = 5;   // X, Y, U, S, PC
  localparam int NPORT  = 3;   // load, swap write-back, destination

  localparam logic [CODE_W-1:0] SEL_D    = 4'd0;
  localparam logic [CODE_W-1:0] SEL_X    = 4'd1;
  localparam logic [CODE_W-1:0] SEL_PC   = 4'd5;
  localparam logic [CODE_W-1:0] BYTE_BASE = 4'd8;  // A=8, B=9, CC=10, DP=11
  localparam int               PC_IDX   = 4;       // index of PC in word array
endpackage

// File: rtl/regxfer_read.sv
module regxfer_read
  import regxfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [CODE_W-1:0]             sel,
  input  logic [NBYTE-1:0][BYTE_W-1:0]  bytes_q,
  input  logic [NWORD-1:0][WORD_W-1:0]  words_q,
  output logic [WORD_W-1:0]             value
);
  always_comb begin
    value = '1;  // unlisted code reads all ones
    if (sel == SEL_D) value = {bytes_q[0], bytes_q[1]};
    for (int j = 0; j < NWORD; j++)
      if (sel == CODE_W'(j + 1)) value = words_q[j];
    for (int i = 0; i < NBYTE; i++)
      if (sel == BYTE_BASE + CODE_W'(i)) value = {{BYTE_W{1'b0}}, bytes_q[i]};
  end
endmodule

// File: rtl/regxfer_regfile.sv
module regxfer_regfile
  import regxfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int unsigned RESET_PC = 0,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NPORT-1:0]                  wr_en,
  input  logic [NPORT-1:0][CODE_W-1:0]      wr_code,
  input  logic [NPORT-1:0][WORD_W-1:0]      wr_data,
  output logic [NBYTE-1:0][BYTE_W-1:0]      bytes_q,
  output logic [NWORD-1:0][WORD_W-1:0]      words_q
);
  logic [NBYTE-1:0][BYTE_W-1:0] bytes_d;
  logic [NWORD-1:0][WORD_W-1:0] words_d;

  // Higher port index is applied later and therefore wins.
  always_comb begin
    bytes_d = bytes_q;
    words_d = words_q;
    for (int p = 0; p < NPORT; p++) begin
      if (wr_en[p]) begin
        for (int i = 0; i < NBYTE; i++)
          if (wr_code[p] == BYTE_BASE + CODE_W'(i)) bytes_d[i] = wr_data[p][BYTE_W-1:0];
        for (int j = 0; j < NWORD; j++)
          if (wr_code[p] == CODE_W'(j + 1)) words_d[j] = wr_data[p];
        if (wr_code[p] == SEL_D) begin
          bytes_d[0] = wr_data[p][WORD_W-1:BYTE_W];
          bytes_d[1] = wr_data[p][BYTE_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_q         <= '0;
      words_q         <= '0;
      words_q[PC_IDX] <= WORD_W'(RESET_PC);
    end else begin
      bytes_q <= bytes_d;
      words_q <= words_d;
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> ($stable(bytes_q) && $stable(words_q)));
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int unsigned RESET_PC = 0,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_swap,
  input  logic [7:0]        op_sel,
  input  logic              ld_en,
  input  logic [3:0]        ld_code,
  input  logic [WORD_W-1:0] ld_data,
  output logic              done,
  output logic              pc_changed,
  output logic [BYTE_W-1:0] reg_a,
  output logic [BYTE_W-1:0] reg_b,
  output logic [WORD_W-1:0] reg_x,
  output logic [WORD_W-1:0] reg_y,
  output logic [WORD_W-1:0] reg_u,
  output logic [WORD_W-1:0] reg_s,
  output logic [WORD_W-1:0] reg_pc,
  output logic [BYTE_W-1:0] reg_cc,
  output logic [BYTE_W-1:0] reg_dp
);
  logic [NBYTE-1:0][BYTE_W-1:0]  bytes_q;
  logic [NWORD-1:0][WORD_W-1:0]  words_q;
  logic [1:0][CODE_W-1:0]        rd_sel;   // 0 = source, 1 = destination
  logic [1:0][WORD_W-1:0]        rd_val;
  logic [NPORT-1:0]              wr_en;
  logic [NPORT-1:0][CODE_W-1:0]  wr_code;
  logic [NPORT-1:0][WORD_W-1:0]  wr_data;
  logic                          done_q, pcchg_q;

  assign rd_sel[0] = op_sel[7:4];
  assign rd_sel[1] = op_sel[3:0];

  for (genvar g = 0; g < 2; g++) begin : g_rd
    regxfer_read #(.BYTE_W(BYTE_W)) u_rd (
      .sel(rd_sel[g]), .bytes_q(bytes_q), .words_q(words_q), .value(rd_val[g])
    );
  end

  // port 0: load, port 1: swap write-back into source, port 2: destination
  assign wr_en[0]   = ld_en;
  assign wr_code[0] = ld_code;
  assign wr_data[0] = ld_data;
  assign wr_en[1]   = op_valid & op_swap;
  assign wr_code[1] = rd_sel[0];
  assign wr_data[1] = rd_val[1];
  assign wr_en[2]   = op_valid;
  assign wr_code[2] = rd_sel[1];
  assign wr_data[2] = rd_val[0];

  regxfer_regfile #(.BYTE_W(BYTE_W), .RESET_PC(RESET_PC)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
    .bytes_q(bytes_q), .words_q(words_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      pcchg_q <= 1'b0;
    end else begin
      done_q  <= op_valid;
      pcchg_q <= op_valid & ((rd_sel[1] == SEL_PC) | (op_swap & (rd_sel[0] == SEL_PC)));
    end
  end

  assign done       = done_q;
  assign pc_changed = pcchg_q;
  assign reg_a  = bytes_q[0];
  assign reg_b  = bytes_q[1];
  assign reg_cc = bytes_q[2];
  assign reg_dp = bytes_q[3];
  assign reg_x  = words_q[0];
  assign reg_y  = words_q[1];
  assign reg_u  = words_q[2];
  assign reg_s  = words_q[3];
  assign reg_pc = words_q[4];

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !done);
  // R8
  pc_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[3:0] == 4'd5) |=> pc_changed);
  // R8
  pc_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
    pc_changed |-> done);
  // R2
  copy_xy_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_swap && op_sel == 8'h12 && !ld_en) |=> (reg_y == $past(reg_x) && $stable(reg_x)));
  // R5
  swap_xy_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_swap && op_sel == 8'h12 && !ld_en) |=> (reg_y == $past(reg_x) && reg_x == $past(reg_y)));
  // R3
  d_split_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_swap && op_sel == 8'h10 && !ld_en) |=> ({reg_a, reg_b} == $past(reg_x)));
  // R6
  bad_src_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_swap && op_sel == 8'h61 && !ld_en) |=> (reg_x == '1));
endmodule

// File: tb/regxfer_unit_bench.sv
module regxfer_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0, op_swap = 1'b0, ld_en = 1'b0;
  logic [7:0]  op_sel = '0;
  logic [3:0]  ld_code = '0;
  logic [15:0] ld_data = '0;
  logic done, pc_changed;
  logic [7:0]  reg_a, reg_b, reg_cc, reg_dp;
  logic [15:0] reg_x, reg_y, reg_u, reg_s, reg_pc;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regxfer_unit #(.BYTE_W(8), .RESET_PC(32'hF000)) u_regxfer_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_swap(op_swap), .op_sel(op_sel),
    .ld_en(ld_en), .ld_code(ld_code), .ld_data(ld_data), .done(done), .pc_changed(pc_changed),
    .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u),
    .reg_s(reg_s), .reg_pc(reg_pc), .reg_cc(reg_cc), .reg_dp(reg_dp)
  );

  // {swap, sel, code1, exp1, code2, exp2, pc_changed}
  // Start state: A=12 B=34 X=1111 Y=2222 U=3333 S=4444 PC=5555 CC=C5 DP=7E
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 8'h12, 4'h2, 16'h1111, 4'h1, 16'h1111, 1'b0}, // R2 X->Y
    {1'b0, 8'h01, 4'h1, 16'h1234, 4'h8, 16'h0012, 1'b0}, // R3 D->X
    {1'b0, 8'h18, 4'h8, 16'h0011, 4'h9, 16'h0034, 1'b0}, // R4 X->A low byte
    {1'b0, 8'hA3, 4'h3, 16'h00C5, 4'hA, 16'h00C5, 1'b0}, // R4 CC->U zero-ext
    {1'b0, 8'h25, 4'h5, 16'h2222, 4'h2, 16'h2222, 1'b1}, // R8 Y->PC
    {1'b0, 8'h30, 4'h0, 16'h3333, 4'h9, 16'h0033, 1'b0}, // R3 U->D
    {1'b1, 8'h12, 4'h1, 16'h2222, 4'h2, 16'h1111, 1'b0}, // R5 X<->Y
    {1'b1, 8'h89, 4'h8, 16'h0034, 4'h9, 16'h0012, 1'b0}, // R5 A<->B
    {1'b1, 8'h01, 4'h0, 16'h1111, 4'h1, 16'h1234, 1'b0}, // R5 D<->X
    {1'b1, 8'h84, 4'h8, 16'h0044, 4'h4, 16'h0012, 1'b0}, // R4 A<->S
    {1'b1, 8'h53, 4'h5, 16'h3333, 4'h3, 16'h5555, 1'b1}, // R8 PC<->U
    {1'b1, 8'h35, 4'h5, 16'h3333, 4'h3, 16'h5555, 1'b1}, // R8 U<->PC
    {1'b0, 8'h61, 4'h1, 16'hFFFF, 4'h2, 16'h2222, 1'b0}, // R6 bad src->X
    {1'b0, 8'h78, 4'h8, 16'h00FF, 4'h9, 16'h0034, 1'b0}, // R6 bad src->A
    {1'b0, 8'h16, 4'h1, 16'h1111, 4'h2, 16'h2222, 1'b0}, // R7 X->bad
    {1'b1, 8'h1F, 4'h1, 16'hFFFF, 4'h2, 16'h2222, 1'b0}, // R6 X<->bad
    {1'b1, 8'h08, 4'h8, 16'h0034, 4'h9, 16'h0012, 1'b0}, // R11 D<->A overlap
    {1'b1, 8'hBA, 4'hB, 16'h00C5, 4'hA, 16'h007E, 1'b0}, // R5 DP<->CC
    {1'b0, 8'h51, 4'h1, 16'h5555, 4'h5, 16'h5555, 1'b0}  // R2 PC->X
  };

  function automatic logic [15:0] get(input logic [3:0] c);
    case (c)
      4'h0: get = {reg_a, reg_b};
      4'h1: get = reg_x;
      4'h2: get = reg_y;
      4'h3: get = reg_u;
      4'h4: get = reg_s;
      4'h5: get = reg_pc;
      4'h8: get = {8'h00, reg_a};
      4'h9: get = {8'h00, reg_b};
      4'hA: get = {8'h00, reg_cc};
      4'hB: get = {8'h00, reg_dp};
      default: get = 16'hDEAD;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] c, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_code = c; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic preload();
    load(4'h0, 16'h1234);
    load(4'h1, 16'h1111);
    load(4'h2, 16'h2222);
    load(4'h3, 16'h3333);
    load(4'h4, 16'h4444);
    load(4'h5, 16'h5555);
    load(4'hA, 16'h00C5);
    load(4'hB, 16'h007E);
  endtask

  task automatic check_start(input string req);
    check(req, {reg_a, reg_b}, 16'h1234);
    check(req, reg_x, 16'h1111);
    check(req, reg_y, 16'h2222);
    check(req, reg_u, 16'h3333);
    check(req, reg_s, 16'h4444);
    check(req, reg_pc, 16'h5555);
    check(req, {reg_cc, reg_dp}, 16'hC57E);
  endtask

  // op launched at a negedge, results sampled at the following negedge
  task automatic run_op(input logic sw, input logic [7:0] sel);
    @(negedge clk);
    op_valid = 1'b1; op_swap = sw; op_sel = sel;
    @(negedge clk);
    op_valid = 1'b0; op_swap = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 a/b", {reg_a, reg_b}, 16'h0000);
    check("R1 x", reg_x, 16'h0000);
    check("R1 s", reg_s, 16'h0000);
    check("R1 pc", reg_pc, 16'hF000);
    check("R1 cc/dp", {reg_cc, reg_dp}, 16'h0000);
    check("R1 done/pcchg", {15'd0, done | pc_changed}, 16'h0000);

    for (int v = 0; v < NVEC; v++) begin
      preload();
      run_op(VEC[v][49], VEC[v][48:41]);
      check($sformatf("R2/R5 vec %0d reg1", v), get(VEC[v][40:37]), VEC[v][36:21]);
      check($sformatf("R2/R5 vec %0d reg2", v), get(VEC[v][20:17]), VEC[v][16:1]);
      check($sformatf("R9 vec %0d done", v), {15'd0, done}, 16'h0001);
      check($sformatf("R8 vec %0d pc_changed", v), {15'd0, pc_changed}, {15'd0, VEC[v][0]});
      @(negedge clk);
      check($sformatf("R9 vec %0d done falls", v), {15'd0, done | pc_changed}, 16'h0000);
    end

    // R7: write to unlisted destination leaves every register untouched
    preload();
    run_op(1'b0, 8'h1C);
    check_start("R7 bad dest");

    // R10: load sizing and no strobes
    @(negedge clk);
    ld_en = 1'b1; ld_code = 4'h8; ld_data = 16'hBEEF;
    @(negedge clk);
    ld_en = 1'b0;
    check("R10 load A low byte", {8'h00, reg_a}, 16'h00EF);
    check("R10 load no done", {15'd0, done}, 16'h0000);
    load(4'h5, 16'h7777);
    check("R10 load pc", reg_pc, 16'h7777);
    check("R10 load pc no pc_changed", {15'd0, pc_changed}, 16'h0000);

    // R11: load and operation on the same register
    preload();
    @(negedge clk);
    op_valid = 1'b1; op_sel = 8'h12; ld_en = 1'b1; ld_code = 4'h2; ld_data = 16'hABCD;
    @(negedge clk);
    op_valid = 1'b0; ld_en = 1'b0;
    check("R11 op beats load", reg_y, 16'h1111);
    // R11: load and operation on different registers
    @(negedge clk);
    op_valid = 1'b1; op_sel = 8'h24; ld_en = 1'b1; ld_code = 4'h3; ld_data = 16'h9999;
    @(negedge clk);
    op_valid = 1'b0; ld_en = 1'b0;
    check("R11 disjoint op", reg_s, 16'h1111);
    check("R11 disjoint load", reg_u, 16'h9999);

    // R12: idle cycles change nothing
    preload();
    repeat (5) @(negedge clk);
    check_start("R12 idle");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule